// File: doc/BRIEF.md
# Periodic-Correction Fractional Clock Divider

This block sits between a 512 Hz enable tick and a hundredths-of-seconds counter. It turns 512 input ticks into exactly 100 evenly spread output pulses, and it raises a seconds tick on the last pulse of each second. A sign-magnitude calibration value can trim timekeeping. In selected seconds, one second's worth of 100 pulses is produced from 511 input ticks, which makes the clock run fast, or from 513 input ticks, which makes it run slow. Each such second therefore ends 1/512 s early or late.

A free-running position counter tracks the second within the minute and the minute modulo the long cycle. Positive trimming applies to the first N seconds of every 8-minute cycle. Negative trimming applies to the first N seconds of every 16-minute cycle. A small state machine holds the rate of the current second and has three states: `RATE_NOM` (512 ticks), `RATE_FAST` (511 ticks) and `RATE_SLOW` (513 ticks). The state machine moves only at a second boundary. At that boundary it takes one of three transitions:
- *hold-nominal*, to `RATE_NOM`, when the coming second is not selected or the magnitude is zero;
- *enter-fast*, to `RATE_FAST`, when the coming second is selected and the sign bit is 1;
- *enter-slow*, to `RATE_SLOW`, when the coming second is selected and the sign bit is 0.

Any state can take any of the three transitions. Between boundaries the state machine takes *stay*.

Top module: `cal_frac_divider`

## Requirements
- R1: With no trimming active in a second, that second spans exactly 512 input ticks and carries exactly 100 pulses on `tick_100`, and `rate_mode` reads 2'b00 during it.
- R2: `tick_sec` pulses for one cycle, in the same cycle as the 100th `tick_100` pulse of the second, and never without a `tick_100` pulse.
- R3: A second selected for positive trimming spans 511 input ticks with 100 pulses, and `rate_mode` reads 2'b01 during it.
- R4: A second selected for negative trimming spans 513 input ticks with 100 pulses, and `rate_mode` reads 2'b10 during it.
- R5: `sec_idx` counts 0 to SECS_PER_MIN-1 and `min_idx` counts minutes modulo NEG_CYCLE_MIN. Both start at 0 after reset and advance in the cycle in which `tick_sec` is high.
- R6: With magnitude N = `cal_wdata[4:0]` and sign = `cal_wdata[5]`, a second is trimmed exactly when N is non-zero and its `sec_idx` is below N. For sign 1, `min_idx` modulo POS_CYCLE_MIN must also be 0; for sign 0, `min_idx` must be 0. When N exceeds the minute length, every second of the selected minute is trimmed.
- R7: A magnitude of zero leaves every second at 512 ticks, whatever the sign bit.
- R8: A write through `cal_we`/`cal_wdata` takes effect from the next second boundary. The current second keeps its rate. A write in the same cycle as a boundary takes effect at the boundary after that.
- R9: Within any second, the first pulse comes 6 input ticks after the second starts. Each later pulse comes 5 or 6 input ticks after the one before it.
- R10: Cycles with `tick_in` low change nothing: the count of input ticks per second is the same whatever the gaps between ticks.
- R11: Over one full cycle of 8·SECS_PER_MIN seconds with positive N ≤ SECS_PER_MIN, the input ticks total 512 per second minus N. Over 16·SECS_PER_MIN seconds with negative N, they total 512 per second plus N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | 512 Hz enable tick, one cycle wide |
| cal_we | input | 1 | Calibration write strobe |
| cal_wdata | input | 6 | Calibration value: bit 5 is the sign, bits 4:0 are the magnitude |
| tick_100 | output | 1 | Registered 100 Hz output pulse |
| tick_sec | output | 1 | Registered once-per-second pulse |
| sec_idx | output | $clog2(SECS_PER_MIN) | Second within the minute |
| min_idx | output | $clog2(NEG_CYCLE_MIN) | Minute modulo the long cycle |
| rate_mode | output | 2 | Rate of the current second: 00 nominal, 01 fast, 10 slow |

## Verification
The bench measures the input ticks in every second and compares the count with a position model built from the selection rule. Several faults would show up as a wrong count:
- an off-by-one in the seconds comparison would trim N+1 seconds or N-1 seconds;
- using the 16-minute check for the positive sign would skip the eighth minute;
- taking a write in the middle of a second would break that second's count.

The bench also runs a second with gaps between input ticks, which catches an accumulator that advances without a tick. Two further cases target the corners: a zero magnitude with the sign bit set, and a magnitude larger than the minute. Sums over a full cycle catch drift that single-second checks could miss.

// File: rtl/cal_div_pkg.sv
package cal_div_pkg;
    typedef enum logic [1:0] {
        RATE_NOM  = 2'b00,
        RATE_FAST = 2'b01,
        RATE_SLOW = 2'b10
    } rate_e;

    localparam int CAL_W = 6;
    localparam int MAG_W = 5;
endpackage

// File: rtl/cal_time_track.sv
module cal_time_track #(
    parameter int SECS_PER_MIN  = 60,
    parameter int NEG_CYCLE_MIN = 16,
    parameter int SEC_W         = 6,
    parameter int MIN_W         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [SEC_W-1:0] sec_q,
    output logic [MIN_W-1:0] min_q,
    output logic [SEC_W-1:0] sec_nx,
    output logic [MIN_W-1:0] min_nx
);
    // Position after one step; used by the rate FSM to pick the coming second's rate.
    always_comb begin
        sec_nx = sec_q;
        min_nx = min_q;
        if (sec_q == SEC_W'(SECS_PER_MIN - 1)) begin
            sec_nx = '0;
            min_nx = (min_q == MIN_W'(NEG_CYCLE_MIN - 1)) ? '0 : min_q + 1'b1;
        end else begin
            sec_nx = sec_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            min_q <= '0;
        end else if (step) begin
            sec_q <= sec_nx;
            min_q <= min_nx;
        end
    end

    a_r5_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
        sec_q < SEC_W'(SECS_PER_MIN));

    a_r5_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(sec_q) && $stable(min_q));
endmodule

// File: rtl/cal_rate_fsm.sv
module cal_rate_fsm
    import cal_div_pkg::*;
#(
    parameter int SEC_W = 6,
    parameter int MIN_W = 4,
    parameter int POS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_we,
    input  logic [CAL_W-1:0] cal_wdata,
    input  logic             boundary,
    input  logic [SEC_W-1:0] sec_nx,
    input  logic [MIN_W-1:0] min_nx,
    output rate_e            rate
);
    logic [CAL_W-1:0] cal_pend;
    logic [CAL_W-1:0] cal_act;
    rate_e            state_q;
    rate_e            state_d;
    logic [MAG_W-1:0] mag;
    logic             sign_pos;
    logic             in_window;
    logic             cycle_start;
    logic             pick;

    // The value that becomes active at this boundary decides the coming second.
    assign mag      = cal_pend[MAG_W-1:0];
    assign sign_pos = cal_pend[CAL_W-1];

    always_comb begin
        in_window   = ({{(32-SEC_W){1'b0}}, sec_nx} < {{(32-MAG_W){1'b0}}, mag});
        cycle_start = sign_pos ? (min_nx[POS_W-1:0] == '0) : (min_nx == '0);
        pick        = (mag != '0) && in_window && cycle_start;
    end

    // Next state: transitions hold-nominal, enter-fast, enter-slow, stay.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RATE_NOM, RATE_FAST, RATE_SLOW: begin
                if (boundary) begin
                    if (!pick)         state_d = RATE_NOM;
                    else if (sign_pos) state_d = RATE_FAST;
                    else               state_d = RATE_SLOW;
                end
            end
            default: state_d = RATE_NOM;
        endcase
    end

    // State register and calibration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RATE_NOM;
            cal_pend <= '0;
            cal_act  <= '0;
        end else begin
            state_q <= state_d;
            if (boundary) cal_act  <= cal_pend;
            if (cal_we)   cal_pend <= cal_wdata;
        end
    end

    // Output process.
    always_comb rate = state_q;

    a_r7_zero_mag_nominal: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != RATE_NOM) |-> (cal_act[MAG_W-1:0] != '0));

    a_r6_sign_matches_rate: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == RATE_FAST) |-> cal_act[CAL_W-1]) and
        ((state_q == RATE_SLOW) |-> !cal_act[CAL_W-1]));

    a_r8_hold_mid_second: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(state_q) && $stable(cal_act));
endmodule

// File: rtl/cal_phase_acc.sv
module cal_phase_acc
    import cal_div_pkg::*;
#(
    parameter int PULSES    = 100,
    parameter int TICKS_NOM = 512
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_in,
    input  rate_e rate,
    output logic  pulse_q,
    output logic  sec_q,
    output logic  boundary
);
    localparam int ACC_W = $clog2(TICKS_NOM + PULSES + 2);
    localparam int CNT_W = $clog2(PULSES);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] modulus;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             fire;

    always_comb begin
        unique case (rate)
            RATE_FAST: modulus = ACC_W'(TICKS_NOM - 1);
            RATE_SLOW: modulus = ACC_W'(TICKS_NOM + 1);
            default:   modulus = ACC_W'(TICKS_NOM);
        endcase
    end

    always_comb begin
        sum      = acc_q + ACC_W'(PULSES);
        fire     = tick_in && (sum >= modulus);
        boundary = fire && (cnt_q == CNT_W'(PULSES - 1));
        if (!tick_in)      acc_d = acc_q;
        else if (boundary) acc_d = '0;
        else if (fire)     acc_d = sum - modulus;
        else               acc_d = sum;
        if (boundary)  cnt_d = '0;
        else if (fire) cnt_d = cnt_q + 1'b1;
        else           cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
            sec_q   <= 1'b0;
        end else begin
            acc_q   <= acc_d;
            cnt_q   <= cnt_d;
            pulse_q <= fire;
            sec_q   <= boundary;
        end
    end

    a_r9_acc_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < modulus);

    a_r2_sec_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sec_q |-> pulse_q);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_in |=> $stable(acc_q) && $stable(cnt_q) && !pulse_q);
endmodule

// File: rtl/cal_frac_divider.sv
module cal_frac_divider
    import cal_div_pkg::*;
#(
    parameter int PULSES        = 100,
    parameter int TICKS_NOM     = 512,
    parameter int SECS_PER_MIN  = 60,
    parameter int POS_CYCLE_MIN = 8,
    parameter int NEG_CYCLE_MIN = 16,
    localparam int SEC_W        = $clog2(SECS_PER_MIN),
    localparam int MIN_W        = $clog2(NEG_CYCLE_MIN),
    localparam int POS_W        = $clog2(POS_CYCLE_MIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic             cal_we,
    input  logic [5:0]       cal_wdata,
    output logic             tick_100,
    output logic             tick_sec,
    output logic [SEC_W-1:0] sec_idx,
    output logic [MIN_W-1:0] min_idx,
    output logic [1:0]       rate_mode
);
    rate_e            rate;
    logic             boundary;
    logic [SEC_W-1:0] sec_nx;
    logic [MIN_W-1:0] min_nx;

    cal_phase_acc #(
        .PULSES    (PULSES),
        .TICKS_NOM (TICKS_NOM)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (tick_in),
        .rate     (rate),
        .pulse_q  (tick_100),
        .sec_q    (tick_sec),
        .boundary (boundary)
    );

    cal_time_track #(
        .SECS_PER_MIN  (SECS_PER_MIN),
        .NEG_CYCLE_MIN (NEG_CYCLE_MIN),
        .SEC_W         (SEC_W),
        .MIN_W         (MIN_W)
    ) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (boundary),
        .sec_q  (sec_idx),
        .min_q  (min_idx),
        .sec_nx (sec_nx),
        .min_nx (min_nx)
    );

    cal_rate_fsm #(
        .SEC_W (SEC_W),
        .MIN_W (MIN_W),
        .POS_W (POS_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cal_we    (cal_we),
        .cal_wdata (cal_wdata),
        .boundary  (boundary),
        .sec_nx    (sec_nx),
        .min_nx    (min_nx),
        .rate      (rate)
    );

    assign rate_mode = rate;

    a_r5_advance_on_sec: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_sec |-> $stable(sec_idx));
endmodule

// File: tb/cal_frac_divider_test.sv
module cal_frac_divider_test;
    localparam int SPM = 6;
    localparam int NOM = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_in = 1'b0;
    logic       cal_we = 1'b0;
    logic [5:0] cal_wdata = '0;
    logic       tick_100;
    logic       tick_sec;
    logic [2:0] sec_idx;
    logic [3:0] min_idx;
    logic [1:0] rate_mode;

    always #10 clk = ~clk;

    cal_frac_divider #(.SECS_PER_MIN(SPM)) uut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .cal_we(cal_we),
        .cal_wdata(cal_wdata), .tick_100(tick_100), .tick_sec(tick_sec),
        .sec_idx(sec_idx), .min_idx(min_idx), .rate_mode(rate_mode)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int mode_for(input int s, input int m, input logic [5:0] c);
        int mag = int'(c[4:0]);
        if (mag != 0 && s < mag && (c[5] ? (m % 8 == 0) : (m == 0)))
            return c[5] ? 1 : 2;
        return 0;
    endfunction

    // Monitor: bench-side position model, sampled 2 ns after each rising edge.
    int tk_cnt = 0, gap_cnt = 0, p_cnt = 0, secs_seen = 0, total = 0, last_len = 0;
    int e_sec = 0, e_min = 0, cur_mode = 0;
    logic [5:0] b_pend = '0, b_act = '0;

    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (tick_in) begin tk_cnt++; gap_cnt++; end
            if (tick_100) begin
                p_cnt++;
                if (p_cnt == 1) check(gap_cnt == 6, "R9", "first pulse spacing", gap_cnt, 6);
                else check(gap_cnt == 5 || gap_cnt == 6, "R9", "pulse spacing", gap_cnt, 5);
                gap_cnt = 0;
            end
            if (tick_sec) begin
                int exp_len;
                string rq;
                exp_len = NOM - (cur_mode == 1 ? 1 : 0) + (cur_mode == 2 ? 1 : 0);
                rq = (cur_mode == 1) ? "R3" : (cur_mode == 2) ? "R4" : "R1";
                check(tk_cnt == exp_len, rq, "ticks per second", tk_cnt, exp_len);
                check(p_cnt == 100 && tick_100, "R2", "pulses at seconds tick", p_cnt, 100);
                total += tk_cnt;
                last_len = tk_cnt;
                e_sec++;
                if (e_sec == SPM) begin e_sec = 0; e_min = (e_min + 1) % 16; end
                b_act = b_pend;
                cur_mode = mode_for(e_sec, e_min, b_act);
                check(int'(sec_idx) == e_sec && int'(min_idx) == e_min, "R5",
                      "position sec*16+min", int'(sec_idx) * 16 + int'(min_idx), e_sec * 16 + e_min);
                check(int'(rate_mode) == cur_mode, "R6", "rate of coming second",
                      int'(rate_mode), cur_mode);
                tk_cnt = 0; p_cnt = 0; gap_cnt = 0;
                secs_seen++;
            end else if (!tick_100 && p_cnt == 0 && gap_cnt > 6) begin
                check(0, "R9", "late first pulse", gap_cnt, 6);
            end
            if (cal_we) b_pend = cal_wdata;
        end
    end

    task automatic advance(input int n, input bit gaps);
        int target = secs_seen + n;
        int ph = 0;
        while (secs_seen < target) begin
            @(negedge clk);
            tick_in = gaps ? (ph % 3 == 0) : 1'b1;
            ph++;
        end
        @(negedge clk);
        tick_in = 1'b0;
    endtask

    task automatic run_ticks(input int k);
        repeat (k) begin
            @(negedge clk);
            tick_in = 1'b1;
        end
        @(negedge clk);
        tick_in = 1'b0;
    endtask

    task automatic write_cal(input logic [5:0] v);
        @(negedge clk);
        cal_we = 1'b1;
        cal_wdata = v;
        @(negedge clk);
        cal_we = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(tick_100 == 0 && tick_sec == 0, "R2", "pulses idle in reset", tick_100, 0);
        check(sec_idx == 0 && min_idx == 0, "R5", "position after reset", sec_idx, 0);
        check(rate_mode == 2'b00, "R1", "rate after reset", rate_mode, 0);
    endtask

    task automatic t_nominal;
        advance(3, 1'b0);
        check(last_len == NOM, "R1", "nominal second length", last_len, NOM);
    endtask

    task automatic t_gaps;
        advance(2, 1'b1);
        check(last_len == NOM, "R10", "length with idle cycles", last_len, NOM);
    endtask

    task automatic t_zero_mag;
        write_cal(6'b100000);
        advance(7, 1'b0);
        check(rate_mode == 2'b00, "R7", "zero magnitude with sign set", rate_mode, 0);
        check(last_len == NOM, "R7", "zero magnitude length", last_len, NOM);
    endtask

    task automatic t_positive;
        int m0;
        run_ticks(200);
        m0 = int'(rate_mode);
        write_cal(6'b100010);
        check(int'(rate_mode) == m0, "R8", "rate unchanged by mid-second write", rate_mode, m0);
        advance(1, 1'b0);
        total = 0;
        advance(8 * SPM, 1'b0);
        check(total == 8 * SPM * NOM - 2, "R11", "positive cycle total", total, 8 * SPM * NOM - 2);
    endtask

    task automatic t_negative;
        write_cal(6'b000011);
        advance(1, 1'b0);
        total = 0;
        advance(16 * SPM, 1'b0);
        check(total == 16 * SPM * NOM + 3, "R11", "negative cycle total", total, 16 * SPM * NOM + 3);
    endtask

    task automatic t_large_mag;
        write_cal(6'b111111);
        advance(1, 1'b0);
        total = 0;
        advance(8 * SPM, 1'b0);
        check(total == 8 * SPM * NOM - SPM, "R6", "magnitude past minute length",
              total, 8 * SPM * NOM - SPM);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_nominal();
        t_gaps();
        t_zero_mag();
        t_positive();
        t_negative();
        t_large_mag();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule